// File: doc/BRIEF.md
# Battery-Backup Power Sequencer

This block decides when a backed-up timekeeping device leaves battery-backup operation and when it returns to it. Two digital flags arrive from analog comparators outside the block. One says the system supply is above the battery by a margin. The other says the system supply is below the battery by a margin. The block retimes both flags. It then drives three outputs that always move together: a power-sense output, a clock-output enable and a CPU run output (the CPU is held in reset while this output is low). It also drives a select that routes the internal supply from the battery pin.

Power-up is hysteretic. The upper-threshold flag only brings the outputs up after the lower-threshold flag has armed the block, and taking power-up consumes that arming. Any loss of the upper flag brings all three outputs down at once.

The block also latches the operating mode from the retimed upper flag when power-on reset ends. It qualifies the mains power-fail sense enable against the clock-source select.

Top module: `bkup_pwr_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pse_o`, `clk_out_en_o`, `cpu_run_o`, `mode_sys_o` and `pf_sense_en_o` are 0 and `on_batt_o` is 1.
- R2: If the block is not armed, a high `sys_hi_i` has no effect: the three power outputs stay low.
- R3: When the block is armed and `sys_hi_i` is high (with `sys_lo_i` low), `pse_o`, `clk_out_en_o` and `cpu_run_o` rise together on the third rising clock edge after the input change: two synchroniser stages plus one state register.
- R4: Taking power-up clears the arming. After the supply drops and recovers without `sys_lo_i` being seen, the outputs stay low.
- R5: When the retimed `sys_hi_i` is low, all three power outputs are 0 after the next edge, with the same three-edge latency from the input.
- R6: `on_batt_o` is 1 whenever the three power outputs are low, in particular whenever the system supply is below the upper threshold. It is 0 while they are high.
- R7: On the first rising edge at which `por_i` is seen low after being high, `mode_sys_o` takes the retimed `sys_hi_i` value (1 = system-powered mode, 0 = battery-only mode). It keeps that value until the next reset.
- R8: `pf_sense_en_o` equals `pf_en_i AND NOT src_line_i` from the previous cycle. `src_line_i` = 1 selects the mains input as the time source, and 0 selects the crystal or external clock.
- R9: If both retimed flags are high in the same cycle, that cycle is ignored. The power outputs and the arming state are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_hi_i | input | 1 | Comparator flag: system supply above battery plus margin (asynchronous) |
| sys_lo_i | input | 1 | Comparator flag: system supply below battery minus margin (asynchronous) |
| por_i | input | 1 | High while power-on reset is active |
| pf_en_i | input | 1 | Power-fail sense enable bit |
| src_line_i | input | 1 | Time-source select: 1 mains input, 0 crystal or external clock |
| pse_o | output | 1 | Power-sense output |
| clk_out_en_o | output | 1 | Clock-output enable |
| cpu_run_o | output | 1 | CPU reset output (high = CPU released) |
| on_batt_o | output | 1 | Internal supply routed from the battery pin |
| mode_sys_o | output | 1 | Operating mode latched at the end of power-on reset |
| pf_sense_en_o | output | 1 | Qualified mains power-fail sense enable |

## Verification
The power outputs are driven with these flag patterns:
- The upper flag alone with no prior arming. This separates a hysteretic design from a plain level follower.
- A full fall-then-rise sequence, sampled one edge before and at the expected edge. This pins the exact three-edge latency.
- A drop and recovery without a new fall. This shows that arming is consumed by power-up.
- Both flags high together, both from the unpowered state and from the powered state. This shows the illegal pair does not arm the block.

Mode capture is tried with the upper flag high and with it low at the end of power-on reset. Later supply changes are then applied to confirm the mode stays latched.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic {
    MODE_BATT_ONLY = 1'b0,
    MODE_SYSTEM    = 1'b1
  } op_mode_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } cmp_flags_t;

  localparam int unsigned CMP_W = $bits(cmp_flags_t);
endpackage

// File: rtl/bps_sync.sv
module bps_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bps_core.sv
module bps_core (
  input  logic clk,
  input  logic rst,
  input  logic hi_s,
  input  logic lo_s,
  output logic armed,
  output logic up
);
  logic armed_d, up_d, illegal;

  assign illegal = hi_s & lo_s;

  always_comb begin
    armed_d = armed;
    up_d    = up;
    if (!illegal) begin
      if (lo_s) armed_d = 1'b1;
      if (!hi_s) begin
        up_d = 1'b0;
      end else if (armed) begin
        up_d    = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      up    <= 1'b0;
    end else begin
      armed <= armed_d;
      up    <= up_d;
    end
  end
endmodule

// File: rtl/bps_mode.sv
module bps_mode
  import bps_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     por_i,
  input  logic     hi_s,
  input  logic     pf_en_i,
  input  logic     src_line_i,
  output op_mode_e mode,
  output logic     pf_sense_en
);
  logic por_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      por_q       <= 1'b0;
      mode        <= MODE_BATT_ONLY;
      pf_sense_en <= 1'b0;
    end else begin
      por_q       <= por_i;
      pf_sense_en <= pf_en_i & ~src_line_i;
      if (por_q && !por_i) mode <= hi_s ? MODE_SYSTEM : MODE_BATT_ONLY;
    end
  end
endmodule

// File: rtl/bkup_pwr_seq.sv
module bkup_pwr_seq
  import bps_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sys_hi_i,
  input  logic sys_lo_i,
  input  logic por_i,
  input  logic pf_en_i,
  input  logic src_line_i,
  output logic pse_o,
  output logic clk_out_en_o,
  output logic cpu_run_o,
  output logic on_batt_o,
  output logic mode_sys_o,
  output logic pf_sense_en_o
);
  cmp_flags_t raw_f, syn_f;
  logic       armed, up;
  op_mode_e   mode;

  assign raw_f.hi = sys_hi_i;
  assign raw_f.lo = sys_lo_i;

  bps_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_f),
    .q   (syn_f)
  );

  bps_core u_core (
    .clk   (clk),
    .rst   (rst),
    .hi_s  (syn_f.hi),
    .lo_s  (syn_f.lo),
    .armed (armed),
    .up    (up)
  );

  bps_mode u_mode (
    .clk         (clk),
    .rst         (rst),
    .por_i       (por_i),
    .hi_s        (syn_f.hi),
    .pf_en_i     (pf_en_i),
    .src_line_i  (src_line_i),
    .mode        (mode),
    .pf_sense_en (pf_sense_en_o)
  );

  assign pse_o        = up;
  assign clk_out_en_o = up;
  assign cpu_run_o    = up;
  assign on_batt_o    = ~up;
  assign mode_sys_o   = (mode == MODE_SYSTEM);
endmodule

// File: rtl/bps_chk.sv
module bps_chk (
  input logic clk,
  input logic rst,
  input logic hi_s,
  input logic lo_s,
  input logic armed,
  input logic por_i,
  input logic pf_en_i,
  input logic src_line_i,
  input logic pse_o,
  input logic on_batt_o,
  input logic mode_sys_o,
  input logic pf_sense_en_o
);
  a_r2_rise_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(pse_o) |-> $past(armed));

  a_r3_rise_on_hi: assert property (@(posedge clk) disable iff (rst)
    $rose(pse_o) |-> ($past(hi_s) && !$past(lo_s)));

  a_r5_drop_forces_low: assert property (@(posedge clk) disable iff (rst)
    !hi_s |=> !pse_o);

  a_r6_batt_when_low: assert property (@(posedge clk) disable iff (rst)
    !hi_s |=> on_batt_o);

  a_r7_mode_held: assert property (@(posedge clk) disable iff (rst)
    (!por_i && !$past(por_i)) |=> $stable(mode_sys_o));

  a_r8_pf_qualify: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pf_sense_en_o == ($past(pf_en_i) && !$past(src_line_i))));

  a_r9_illegal_hold: assert property (@(posedge clk) disable iff (rst)
    (hi_s && lo_s) |=> ($stable(pse_o) && $stable(armed)));
endmodule

bind bkup_pwr_seq bps_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .hi_s          (syn_f.hi),
  .lo_s          (syn_f.lo),
  .armed         (armed),
  .por_i         (por_i),
  .pf_en_i       (pf_en_i),
  .src_line_i    (src_line_i),
  .pse_o         (pse_o),
  .on_batt_o     (on_batt_o),
  .mode_sys_o    (mode_sys_o),
  .pf_sense_en_o (pf_sense_en_o)
);

// File: tb/sim_bkup_pwr_seq.sv
`timescale 1ns/1ps
module sim_bkup_pwr_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_hi = 1'b0, sys_lo = 1'b0, por = 1'b1, pf_en = 1'b0, src_line = 1'b0;
  logic pse, cko, run, batt, mode, pfs;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  bkup_pwr_seq u0 (
    .clk(clk), .rst(rst), .sys_hi_i(sys_hi), .sys_lo_i(sys_lo), .por_i(por),
    .pf_en_i(pf_en), .src_line_i(src_line), .pse_o(pse), .clk_out_en_o(cko),
    .cpu_run_o(run), .on_batt_o(batt), .mode_sys_o(mode), .pf_sense_en_o(pfs)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pw();
    return {4'b0, pse, cko, run, batt};
  endfunction

  localparam logic [7:0] PW_DOWN = 8'h01;
  localparam logic [7:0] PW_UP   = 8'h0E;

  task automatic drive(input logic hi, input logic lo);
    @(negedge clk);
    sys_hi = hi;
    sys_lo = lo;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    por = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset outputs", {pw()[7:2], mode, pfs}, 8'h00);
    chk("R1 reset on_batt", {7'b0, batt}, 8'h01);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    chk("R1 first cycle", {pw()[7:1], mode, pfs, batt} & 8'hFF, {5'b0, 3'b001});
  endtask

  task automatic t_unarmed_and_mode();
    drive(1'b1, 1'b0);
    settle();
    chk("R2 hi without arming", pw(), PW_DOWN);
    @(negedge clk);
    por = 1'b0;
    @(posedge clk);
    #2;
    chk("R7 mode captured system", {7'b0, mode}, 8'h01);
  endtask

  task automatic t_powerup();
    drive(1'b0, 1'b1);
    settle();
    chk("R6 batt while low", pw(), PW_DOWN);
    drive(1'b0, 1'b0);
    settle();
    drive(1'b1, 1'b0);
    repeat (2) @(posedge clk);
    #2;
    chk("R3 not before third edge", pw(), PW_DOWN);
    @(posedge clk);
    #2;
    chk("R3 R6 all up on third edge", pw(), PW_UP);
  endtask

  task automatic t_drop_and_consume();
    drive(1'b0, 1'b0);
    repeat (2) @(posedge clk);
    #2;
    chk("R5 still up before third edge", pw(), PW_UP);
    @(posedge clk);
    #2;
    chk("R5 R6 all low on drop", pw(), PW_DOWN);
    drive(1'b1, 1'b0);
    settle();
    chk("R4 arming consumed", pw(), PW_DOWN);
    chk("R7 mode kept", {7'b0, mode}, 8'h01);
  endtask

  task automatic t_illegal();
    drive(1'b1, 1'b1);
    settle();
    chk("R9 both flags unpowered", pw(), PW_DOWN);
    drive(1'b1, 1'b0);
    settle();
    chk("R9 no arming from both", pw(), PW_DOWN);
    t_powerup();
    drive(1'b1, 1'b1);
    settle();
    chk("R9 both flags powered hold", pw(), PW_UP);
    drive(1'b0, 1'b0);
    settle();
    chk("R5 drop after illegal", pw(), PW_DOWN);
    drive(1'b1, 1'b0);
    settle();
    chk("R9 R4 illegal did not arm", pw(), PW_DOWN);
  endtask

  task automatic t_pf();
    @(negedge clk); pf_en = 1'b1; src_line = 1'b0;
    @(posedge clk); #2;
    chk("R8 enabled with crystal", {7'b0, pfs}, 8'h01);
    @(negedge clk); src_line = 1'b1;
    @(posedge clk); #2;
    chk("R8 blocked by line source", {7'b0, pfs}, 8'h00);
    @(negedge clk); pf_en = 1'b0; src_line = 1'b0;
    @(posedge clk); #2;
    chk("R8 blocked by enable", {7'b0, pfs}, 8'h00);
  endtask

  task automatic t_mode_batt();
    drive(1'b0, 1'b0);
    do_reset();
    settle();
    @(negedge clk);
    por = 1'b0;
    @(posedge clk);
    #2;
    chk("R7 mode captured battery", {7'b0, mode}, 8'h00);
    drive(1'b1, 1'b0);
    settle();
    chk("R7 mode stays battery", {7'b0, mode}, 8'h00);
  endtask

  initial begin
    do_reset();
    t_unarmed_and_mode();
    t_powerup();
    t_drop_and_consume();
    t_illegal();
    t_pf();
    t_mode_batt();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule